// File: doc/BRIEF.md
# Multiplexed Host-Bus Write Slave

This block is the write side of a host port on a shared address/data bus. An external host selects either memory space or I/O space with one of two active-low chip selects. It places a 17-bit address on the bus (16 shared lines plus one address-only line) and pulses an address latch strobe. It then performs one or more data transfers, each framed by an active-low write strobe. The block gathers those transfers into one internal word. Once the last transfer of the word arrives, it posts one write request carrying the address, the space and the data to the memory side. The memory side accepts the request through a request/grant handshake.

All host strobes are asynchronous to the block clock. The block synchronizes each strobe through a flop chain and works on edges of the synchronized copies. A status line paces the host in one of two ways. In handshake mode the line answers every transfer. In ready mode the line only holds off the first transfer of a word, and only while an earlier write is still waiting for grant.

Top module: `hostwr_slave`

## Requirements
- R1: During reset and directly after it, `wreq` is low. With `cfg_ack_mode`=1 the `h_ack` output is also low.
- R2: The address is `{h_a16,h_ad}`, taken when the synchronized latch strobe falls. It is forwarded on `waddr`. `wspace` is 1 when the I/O select (`h_cs_io_n`=0) was active at latch time and the memory select was not, and 0 otherwise.
- R3: A latch strobe is ignored while both chip selects are high. Write transfers that arrive with no honoured address phase produce no request.
- R4: Each transfer's data is taken from the bus at the release (rising edge) of `h_wr_n`. The bus value present when the strobe fell has no effect.
- R5: A word needs a number of transfers that depends on the configuration. With `cfg_bus8`=0 and `cfg_data24`=0 it needs 1. With `cfg_bus8`=0 and `cfg_data24`=1 it needs 2. With `cfg_bus8`=1 and `cfg_data24`=0 it needs 2. With `cfg_bus8`=1 and `cfg_data24`=1 it needs 4.
- R6: Transfers are packed least-significant first. On an 8-bit bus, only `h_ad[7:0]` of each transfer is used. On a 16-bit bus, the second transfer contributes only its low byte, which becomes `wdata[23:16]`. The fourth byte on an 8-bit bus is padding and is dropped. With 16-bit data, `wdata[23:16]` is zero.
- R7: With `cfg_ack_mode`=1, `h_ack` rises after `h_wr_n` falls on every accepted transfer and falls after `h_wr_n` is released.
- R8: With `cfg_ack_mode`=0, `h_ack` is high except while the first transfer of a word is held off. Later transfers of the word are never held off.
- R9: The first transfer of a word is not acknowledged while an earlier request still awaits grant. `h_ack` rises in the cycle after `wgnt` is seen, so it is never high together with a pending request in handshake mode.
- R10: If both chip selects go high before the word is complete, the partial word is discarded and no request is issued.
- R11: After a word completes, further transfers under the same select are ignored and not acknowledged until a new address phase occurs.
- R12: `wreq` holds, with `waddr`, `wspace` and `wdata` stable, until the cycle in which `wgnt` is high. It drops in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ack_mode | input | 1 | 1: handshake per transfer; 0: ready mode |
| cfg_bus8 | input | 1 | 1: 8-bit host bus; 0: 16-bit |
| cfg_data24 | input | 1 | 1: 24-bit words; 0: 16-bit words |
| h_cs_mem_n | input | 1 | Memory-space select, active low, asynchronous |
| h_cs_io_n | input | 1 | I/O-space select, active low, asynchronous |
| h_alatch | input | 1 | Address latch strobe, active high, asynchronous |
| h_wr_n | input | 1 | Write strobe, active low, asynchronous |
| h_ad | input | 16 | Shared address/data lines |
| h_a16 | input | 1 | Address-only top bit |
| h_ack | output | 1 | Acknowledge / ready status to the host |
| wreq | output | 1 | Internal write request |
| wgnt | input | 1 | Grant from the memory side |
| waddr | output | 17 | Write address |
| wspace | output | 1 | 0: memory space, 1: I/O space |
| wdata | output | 24 | Assembled write word |

## Verification
The bench builds the block with the default two-stage synchronizer. It sweeps all four bus-width and data-type combinations in both acknowledge modes. Its memory model grants after five cycles plus an extra delay, which the bench sets to 0 or 40. The long setting keeps a word's request pending while the host starts the next word. That exposes the first-transfer hold-off and the release of the acknowledge one cycle after grant.

// File: rtl/hostwr_slave.sv
`timescale 1ns/1ps
module hostwr_slave #(
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_ack_mode,
  input  logic        cfg_bus8,
  input  logic        cfg_data24,
  input  logic        h_cs_mem_n,
  input  logic        h_cs_io_n,
  input  logic        h_alatch,
  input  logic        h_wr_n,
  input  logic [15:0] h_ad,
  input  logic        h_a16,
  output logic        h_ack,
  output logic        wreq,
  input  logic        wgnt,
  output logic [16:0] waddr,
  output logic        wspace,
  output logic [23:0] wdata
);
  localparam logic [3:0] IDLE_LVL = 4'b1101;

  logic [3:0] pipe [SYNC];
  logic [3:0] prev;
  logic [3:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) pipe[i] <= IDLE_LVL;
      prev <= IDLE_LVL;
    end else begin
      pipe[0] <= {h_cs_mem_n, h_cs_io_n, h_alatch, h_wr_n};
      for (int i = 1; i < SYNC; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[SYNC-1];
    end
  end

  assign cur = pipe[SYNC-1];

  wire mem_sel    = !cur[3];
  wire io_sel     = !cur[2];
  wire sel        = mem_sel | io_sel;
  wire latch_fall = prev[1] & !cur[1];
  wire wr_fall    = prev[0] & !cur[0];
  wire wr_rise    = !prev[0] & cur[0];
  wire wr_act     = !cur[0];

  logic        have_addr, stall_q, ack_q;
  logic [1:0]  beat;
  logic [23:0] asm_q, asm_nxt;
  logic [16:0] addr_q;
  logic        io_q;

  wire [1:0] last_idx = cfg_bus8 ? (cfg_data24 ? 2'd3 : 2'd1) : (cfg_data24 ? 2'd1 : 2'd0);
  wire       path_free = !wreq | wgnt;
  wire       first_ok  = (beat != 2'd0) | path_free;

  always_comb begin
    asm_nxt = asm_q;
    if (cfg_bus8) begin
      case (beat)
        2'd0:    asm_nxt[7:0]   = h_ad[7:0];
        2'd1:    asm_nxt[15:8]  = h_ad[7:0];
        2'd2:    asm_nxt[23:16] = h_ad[7:0];
        default: ;
      endcase
    end else begin
      case (beat)
        2'd0:    asm_nxt[15:0]  = h_ad;
        2'd1:    asm_nxt[23:16] = h_ad[7:0];
        default: ;
      endcase
    end
    if (!cfg_data24) asm_nxt[23:16] = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_addr <= 1'b0;
      beat      <= 2'd0;
      asm_q     <= '0;
      addr_q    <= '0;
      io_q      <= 1'b0;
      wreq      <= 1'b0;
      waddr     <= '0;
      wspace    <= 1'b0;
      wdata     <= '0;
    end else begin
      if (wreq && wgnt) wreq <= 1'b0;
      if (!sel) begin
        have_addr <= 1'b0;
        beat      <= 2'd0;
      end else if (latch_fall) begin
        addr_q    <= {h_a16, h_ad};
        io_q      <= !mem_sel;
        have_addr <= 1'b1;
        beat      <= 2'd0;
        asm_q     <= '0;
      end else if (wr_rise && have_addr) begin
        if (beat == last_idx) begin
          wreq      <= 1'b1;
          waddr     <= addr_q;
          wspace    <= io_q;
          wdata     <= asm_nxt;
          have_addr <= 1'b0;
          beat      <= 2'd0;
        end else begin
          asm_q <= asm_nxt;
          beat  <= beat + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      ack_q <= sel & have_addr & wr_act & first_ok;
      if (!sel)
        stall_q <= 1'b0;
      else if (wr_fall && have_addr && beat == 2'd0 && !path_free)
        stall_q <= 1'b1;
      else if (path_free)
        stall_q <= 1'b0;
    end
  end

  assign h_ack = cfg_ack_mode ? ack_q : !stall_q;
endmodule

module hostwr_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_ack_mode,
  input logic        cfg_data24,
  input logic        h_ack,
  input logic        wreq,
  input logic        wgnt,
  input logic [16:0] waddr,
  input logic        wspace,
  input logic [23:0] wdata
);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wreq && !wgnt |=> wreq && $stable(waddr) && $stable(wdata) && $stable(wspace));

  a_r12_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wreq && wgnt |=> !wreq);

  a_r9_ack_free: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ack_mode && h_ack |-> !wreq);

  a_r9_ready_free: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ack_mode && $rose(h_ack) |-> !wreq);

  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wreq && !cfg_data24 |-> wdata[23:16] == 8'h00);
endmodule

bind hostwr_slave hostwr_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ack_mode(cfg_ack_mode), .cfg_data24(cfg_data24),
  .h_ack(h_ack), .wreq(wreq), .wgnt(wgnt), .waddr(waddr), .wspace(wspace), .wdata(wdata)
);

// File: tb/hostwr_slave_bench.sv
`timescale 1ns/1ps
module hostwr_slave_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_ack_mode = 1'b1, cfg_bus8 = 1'b0, cfg_data24 = 1'b0;
  logic        h_cs_mem_n = 1'b1, h_cs_io_n = 1'b1, h_alatch = 1'b0, h_wr_n = 1'b1;
  logic [15:0] h_ad = 16'h0;
  logic        h_a16 = 1'b0;
  logic        h_ack, wreq, wspace;
  logic        wgnt;
  logic [16:0] waddr;
  logic [23:0] wdata;

  int checks = 0, errors = 0;
  int extra = 0;
  int gcnt;
  logic [41:0] expq [$];

  hostwr_slave u_hostwr_slave (
    .clk(clk), .rst_n(rst_n), .cfg_ack_mode(cfg_ack_mode), .cfg_bus8(cfg_bus8),
    .cfg_data24(cfg_data24), .h_cs_mem_n(h_cs_mem_n), .h_cs_io_n(h_cs_io_n),
    .h_alatch(h_alatch), .h_wr_n(h_wr_n), .h_ad(h_ad), .h_a16(h_a16), .h_ack(h_ack),
    .wreq(wreq), .wgnt(wgnt), .waddr(waddr), .wspace(wspace), .wdata(wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [41:0] act, input logic [41:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgnt <= 1'b0;
      gcnt <= 0;
    end else if (wreq && !wgnt) begin
      if (gcnt >= 4 + extra) begin
        wgnt <= 1'b1;
        gcnt <= 0;
      end else gcnt <= gcnt + 1;
    end else wgnt <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && wreq && wgnt) begin
      logic [41:0] e;
      if (expq.size() == 0)
        chk(1'b0, "R3 R10 R11 unexpected write", {wspace, waddr, wdata}, '0);
      else begin
        e = expq.pop_front();
        chk({wspace, waddr, wdata} == e, "R2 R4 R5 R6 posted word", {wspace, waddr, wdata}, e);
      end
    end
  end

  task automatic push(input bit io, input logic [16:0] a, input logic [23:0] d);
    expq.push_back({io, a, d});
  endtask

  task automatic addr_phase(input bit io, input logic [16:0] a);
    @(negedge clk);
    if (io) h_cs_io_n = 1'b0; else h_cs_mem_n = 1'b0;
    repeat (3) @(negedge clk);
    h_ad = a[15:0]; h_a16 = a[16]; h_alatch = 1'b1;
    repeat (3) @(negedge clk);
    h_alatch = 1'b0;
    repeat (5) @(negedge clk);
    h_ad = 16'hC3C3; h_a16 = ~a[16];
  endtask

  task automatic xfer(input logic [15:0] d, input bit wait_ack, output bit stalled);
    int waited = 0;
    stalled = 1'b0;
    h_ad = 16'h5A5A;
    h_wr_n = 1'b0;
    if (!wait_ack) repeat (8) @(negedge clk);
    else begin
      repeat (5) @(negedge clk);
      stalled = !h_ack;
      while (!h_ack && waited < 400) begin
        @(negedge clk);
        waited++;
      end
      chk(h_ack == 1'b1, "R7 R8 acknowledge arrives", {41'h0, h_ack}, 42'h1);
      chk(wreq == 1'b0, "R9 ack only once path is free", {41'h0, wreq}, 42'h0);
    end
    h_ad = d;
    repeat (2) @(negedge clk);
    h_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    if (wait_ack && cfg_ack_mode)
      chk(h_ack == 1'b0, "R7 ack released after strobe", {41'h0, h_ack}, 42'h0);
  endtask

  task automatic finish_word();
    @(negedge clk);
    h_cs_mem_n = 1'b1; h_cs_io_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_wait();
    int n = 0;
    while ((wreq || expq.size() != 0) && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit st;
    repeat (5) @(negedge clk);
    chk(h_ack == 1'b0, "R1 ack low in reset", {41'h0, h_ack}, 42'h0);
    chk(wreq == 1'b0, "R1 no request in reset", {41'h0, wreq}, 42'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(h_ack == 1'b0 && wreq == 1'b0, "R1 idle after reset", {40'h0, h_ack, wreq}, 42'h0);

    // R5 R6: 16-bit bus, 16-bit data, memory space
    addr_phase(1'b0, 17'h12345);
    push(1'b0, 17'h12345, 24'h00BEEF);
    xfer(16'hBEEF, 1'b1, st);
    chk(st == 1'b0, "R7 ack without hold-off", {41'h0, st}, 42'h0);
    finish_word(); idle_wait();

    // R2 R6: I/O space, 16-bit bus, 24-bit data
    cfg_data24 = 1'b1;
    addr_phase(1'b1, 17'h00100);
    push(1'b1, 17'h00100, 24'h123456);
    xfer(16'h3456, 1'b1, st);
    xfer(16'hFF12, 1'b1, st);
    finish_word(); idle_wait();

    // R5: 8-bit bus, 16-bit data
    cfg_bus8 = 1'b1; cfg_data24 = 1'b0;
    addr_phase(1'b0, 17'h1F00F);
    push(1'b0, 17'h1F00F, 24'h001234);
    xfer(16'hAB34, 1'b1, st);
    xfer(16'hCD12, 1'b1, st);
    finish_word(); idle_wait();

    // R5 R6: 8-bit bus, 24-bit data, padding byte dropped
    cfg_data24 = 1'b1;
    addr_phase(1'b1, 17'h0ABCD);
    push(1'b1, 17'h0ABCD, 24'h123456);
    xfer(16'hEE56, 1'b1, st);
    xfer(16'hEE34, 1'b1, st);
    xfer(16'hEE12, 1'b1, st);
    xfer(16'hEE99, 1'b1, st);
    finish_word(); idle_wait();

    // R3: latch without select, then select without latch
    cfg_bus8 = 1'b0; cfg_data24 = 1'b0;
    @(negedge clk);
    h_ad = 16'h0AAA; h_alatch = 1'b1;
    repeat (3) @(negedge clk);
    h_alatch = 1'b0;
    repeat (5) @(negedge clk);
    h_cs_mem_n = 1'b0;
    repeat (4) @(negedge clk);
    xfer(16'h1111, 1'b0, st);
    chk(h_ack == 1'b0, "R3 stray transfer not acknowledged", {41'h0, h_ack}, 42'h0);
    repeat (20) @(negedge clk);
    chk(wreq == 1'b0 && expq.size() == 0, "R3 no request without address", {41'h0, wreq}, 42'h0);
    finish_word();

    // R11: extra transfer after a complete word
    addr_phase(1'b0, 17'h00042);
    push(1'b0, 17'h00042, 24'h004242);
    xfer(16'h4242, 1'b1, st);
    h_ad = 16'h9999; h_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(h_ack == 1'b0, "R11 extra transfer not acknowledged", {41'h0, h_ack}, 42'h0);
    repeat (3) @(negedge clk);
    h_wr_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(wreq == 1'b0 && expq.size() == 0, "R11 no second request", {41'h0, wreq}, 42'h0);
    finish_word();

    // R10: partial word discarded
    cfg_bus8 = 1'b1; cfg_data24 = 1'b1;
    addr_phase(1'b0, 17'h00777);
    xfer(16'h0001, 1'b1, st);
    xfer(16'h0002, 1'b1, st);
    finish_word();
    repeat (30) @(negedge clk);
    chk(wreq == 1'b0, "R10 partial word dropped", {41'h0, wreq}, 42'h0);
    addr_phase(1'b0, 17'h00778);
    push(1'b0, 17'h00778, 24'hCCBBAA);
    xfer(16'h00AA, 1'b1, st);
    xfer(16'h00BB, 1'b1, st);
    xfer(16'h00CC, 1'b1, st);
    xfer(16'h00DD, 1'b1, st);
    finish_word(); idle_wait();

    // R9: handshake mode hold-off while previous request pending
    cfg_bus8 = 1'b0; cfg_data24 = 1'b0; extra = 40;
    addr_phase(1'b0, 17'h00010);
    push(1'b0, 17'h00010, 24'h000A0A);
    xfer(16'h0A0A, 1'b1, st);
    finish_word();
    addr_phase(1'b1, 17'h10020);
    push(1'b1, 17'h10020, 24'h000B0B);
    xfer(16'h0B0B, 1'b1, st);
    chk(st == 1'b1, "R9 first transfer held off", {41'h0, st}, 42'h1);
    finish_word(); idle_wait();

    // R8: ready mode
    cfg_ack_mode = 1'b0; cfg_data24 = 1'b1;
    repeat (2) @(negedge clk);
    chk(h_ack == 1'b1, "R8 ready line idles high", {41'h0, h_ack}, 42'h1);
    addr_phase(1'b0, 17'h00300);
    push(1'b0, 17'h00300, 24'h225566);
    xfer(16'h5566, 1'b1, st);
    chk(st == 1'b0, "R8 no hold-off on free path", {41'h0, st}, 42'h0);
    xfer(16'h0022, 1'b1, st);
    finish_word();
    addr_phase(1'b1, 17'h00301);
    push(1'b1, 17'h00301, 24'h447788);
    xfer(16'h7788, 1'b1, st);
    chk(st == 1'b1, "R8 first transfer held off", {41'h0, st}, 42'h1);
    xfer(16'h0044, 1'b1, st);
    chk(st == 1'b0, "R8 later transfer not held off", {41'h0, st}, 42'h0);
    finish_word(); idle_wait();
    extra = 0;

    chk(expq.size() == 0, "R2 every word delivered", {10'h0, 32'(expq.size())}, 42'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule